// File: doc/BRIEF.md
# Word-to-Byte Multiplexed Bus Bridge

This block sits between an internal 16-bit requester and an external bus that is only one byte wide and whose upper address byte shares its pins with the data byte. Every accepted internal access becomes exactly two external byte cycles. The first cycle moves the most significant byte at the requested address. The second cycle moves the least significant byte at that address plus one, and the address wraps at the top of the space.

Each byte cycle has two phases. In the address phase the bridge raises an address-latch strobe. It drives the upper address byte on the shared port and the lower address byte on a dedicated port. In the data phase it raises either a read strobe or a write strobe. On a write the bridge keeps driving the shared port, now with the data byte. On a read it releases the shared port so that the external device can drive it. The two returned bytes are assembled into one word, with the first byte in the upper half, and are reported with a one-cycle response strobe.

The request side is a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole transfer, so any request presented in that time is ignored. The requester must keep its request steady until it sees ready. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the consumer must take `rsp_rdata` in that cycle.

Top module: `mux_bus_bridge`

## Requirements
- R1: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. The address phase of the first byte cycle starts in the next cycle. A request presented while the bridge is busy starts no bus cycle.
- R2: In each address phase `bus_ale` is high for one cycle. `bus_ad_o` carries address bits 15:8 with `bus_ad_oe` high, and `bus_alo` carries address bits 7:0. `bus_alo` holds its value through the data phase that follows.
- R3: The second byte cycle uses the requested address plus one, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R4: On a write, the first data phase drives `req_wdata[15:8]` on `bus_ad_o` with `bus_wr` and `bus_ad_oe` high. The second data phase drives `req_wdata[7:0]` in the same way.
- R5: On a read, each data phase raises `bus_rd` with `bus_ad_oe` low. The bridge samples `bus_ad_i` on the clock edge that ends that phase.
- R6: The byte read in the first data phase appears on `rsp_rdata[15:8]` and the byte read in the second appears on `rsp_rdata[7:0]`. Both are valid while `rsp_valid` is high.
- R7: `rsp_valid` is high for exactly one cycle, the cycle right after the second data phase. That is the fifth cycle after the accepting edge.
- R8: `busy` is high from the cycle after acceptance through the `rsp_valid` cycle, and `req_ready` is its inverse.
- R9: While not busy, `bus_ale`, `bus_rd`, `bus_wr` and `bus_ad_oe` are all low.
- R10: At most one of `bus_ale`, `bus_rd` and `bus_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request |
| req_addr | input | 16 | Word address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Assembled read data |
| busy | output | 1 | Transfer in progress |
| bus_alo | output | 8 | Dedicated lower address byte |
| bus_ad_o | output | 8 | Shared port, driven value (upper address or data) |
| bus_ad_oe | output | 1 | Shared port output enable |
| bus_ad_i | input | 8 | Shared port, value from the device |
| bus_ale | output | 1 | Address-latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |

## Verification
Counting from the edge that accepts a request, the first address phase is visible one cycle later. The data phases follow in cycles two and four, the second address phase in cycle three, and the response strobe in cycle five. In cycle six the bus is idle again. The driver task samples at the falling edge of each of these five cycles and requires `rsp_valid` low in the first four and high in the fifth. A bus monitor compares every address phase, write data phase and response against queues that the driver filled from the requirements. Empty queues at the end show that an ignored request caused no extra cycle.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR1 = 3'd1,
    PH_DATA1 = 3'd2,
    PH_ADDR2 = 3'd3,
    PH_DATA2 = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;
endpackage

// File: rtl/mbb_seq.sv
// Phase sequencer: two byte cycles, each an address phase then a data phase.
module mbb_seq
  import mbb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase
);
  phase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:  if (start) nxt = PH_ADDR1;
      PH_ADDR1: nxt = PH_DATA1;
      PH_DATA1: nxt = PH_ADDR2;
      PH_ADDR2: nxt = PH_DATA2;
      PH_DATA2: nxt = PH_DONE;
      PH_DONE:  nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/mbb_addr.sv
// Holds the accepted access and yields the address and byte of the current cycle.
module mbb_addr #(
  parameter  int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] in_addr,
  input  logic              in_write,
  input  logic [WORD_W-1:0] in_wdata,
  input  logic              second,
  output logic [WORD_W-1:0] cur_addr,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              is_write
);
  logic [WORD_W-1:0] base_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      wdata_q  <= '0;
      is_write <= 1'b0;
    end else if (load) begin
      base_q   <= in_addr;
      wdata_q  <= in_wdata;
      is_write <= in_write;
    end
  end

  // Sum truncates to WORD_W bits, so the top address wraps to zero.
  assign cur_addr = base_q + {{(WORD_W-1){1'b0}}, second};
  assign wr_byte  = second ? wdata_q[BYTE_W-1:0] : wdata_q[WORD_W-1:BYTE_W];
endmodule

// File: rtl/mbb_rdcap.sv
// Byte lanes of the read word; lane 1 is the upper half.
module mbb_rdcap #(
  parameter  int BYTE_W = 8,
  localparam int LANES  = 2,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  cap,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (cap[g]) q <= din;
    end
    assign word[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
  import mbb_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              busy,
  output logic [BYTE_W-1:0] bus_alo,
  output logic [BYTE_W-1:0] bus_ad_o,
  output logic              bus_ad_oe,
  input  logic [BYTE_W-1:0] bus_ad_i,
  output logic              bus_ale,
  output logic              bus_rd,
  output logic              bus_wr
);
  phase_e            phase;
  logic              start;
  logic              second;
  logic              data_ph;
  logic              is_write;
  logic [WORD_W-1:0] cur_addr;
  logic [BYTE_W-1:0] wr_byte;
  logic [1:0]        cap;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign busy      = !req_ready;
  assign second    = (phase == PH_ADDR2) || (phase == PH_DATA2);
  assign data_ph   = (phase == PH_DATA1) || (phase == PH_DATA2);

  mbb_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .phase (phase)
  );

  mbb_addr #(.BYTE_W(BYTE_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .in_addr  (req_addr),
    .in_write (req_write),
    .in_wdata (req_wdata),
    .second   (second),
    .cur_addr (cur_addr),
    .wr_byte  (wr_byte),
    .is_write (is_write)
  );

  assign bus_ale   = (phase == PH_ADDR1) || (phase == PH_ADDR2);
  assign bus_rd    = data_ph && !is_write;
  assign bus_wr    = data_ph && is_write;
  assign bus_ad_oe = bus_ale || bus_wr;
  assign bus_ad_o  = bus_ale ? cur_addr[WORD_W-1:BYTE_W] :
                     bus_wr  ? wr_byte : '0;
  assign bus_alo   = (bus_ale || data_ph) ? cur_addr[BYTE_W-1:0] : '0;

  assign cap = {bus_rd && (phase == PH_DATA1), bus_rd && (phase == PH_DATA2)};

  mbb_rdcap #(.BYTE_W(BYTE_W)) u_rdcap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .din   (bus_ad_i),
    .word  (rsp_rdata)
  );

  assign rsp_valid = (phase == PH_DONE);
endmodule

// File: rtl/mbb_checker.sv
module mbb_checker #(
  parameter  int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              busy,
  input logic [BYTE_W-1:0] bus_alo,
  input logic [BYTE_W-1:0] bus_ad_o,
  input logic              bus_ad_oe,
  input logic              bus_ale,
  input logic              bus_rd,
  input logic              bus_wr
);
  logic              second_q;
  logic [WORD_W-1:0] first_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q     <= 1'b0;
      first_addr_q <= '0;
    end else if (bus_ale) begin
      second_q <= !second_q;
      if (!second_q) first_addr_q <= {bus_ad_o, bus_alo};
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && bus_ale));
  p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> bus_ad_oe);
  p_ale_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> ((bus_rd || bus_wr) && $stable(bus_alo)));
  p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale && second_q) |-> ({bus_ad_o, bus_alo} == first_addr_q + 1'b1));
  p_wr_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_ad_oe);
  p_rd_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !bus_ad_oe);
  p_done_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_rd || bus_wr));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_busy_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_ale || bus_rd || bus_wr || bus_ad_oe));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bus_ale, bus_rd, bus_wr}) <= 1);
endmodule

bind mux_bus_bridge mbb_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .busy      (busy),
  .bus_alo   (bus_alo),
  .bus_ad_o  (bus_ad_o),
  .bus_ad_oe (bus_ad_oe),
  .bus_ale   (bus_ale),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr)
);

// File: tb/mux_bus_bridge_bench.sv
`timescale 1ns/1ps
module mux_bus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        busy;
  logic [7:0]  bus_alo;
  logic [7:0]  bus_ad_o;
  logic        bus_ad_oe;
  logic [7:0]  bus_ad_i = '0;
  logic        bus_ale;
  logic        bus_rd;
  logic        bus_wr;

  always #2.5 clk = ~clk;

  mux_bus_bridge u_mux_bus_bridge (.*);

  int checks = 0;
  int errors = 0;
  logic [15:0] q_addr[$];
  logic [23:0] q_wr[$];
  logic [16:0] q_rsp[$];
  logic [15:0] dev_la = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // External device model and bus monitor (scoreboard side).
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_ale) begin
        if (q_addr.size() == 0)
          check(0, "R1", "unexpected address phase", {bus_ad_o, bus_alo}, 0);
        else begin
          logic [15:0] ea;
          ea = q_addr.pop_front();
          check({bus_ad_o, bus_alo} == ea, "R3", "address phase value", {bus_ad_o, bus_alo}, ea);
          check(bus_ad_oe, "R2", "shared port driven in address phase", bus_ad_oe, 1);
        end
        dev_la = {bus_ad_o, bus_alo};
      end
      if (bus_rd) begin
        check(!bus_ad_oe, "R5", "shared port released on read", bus_ad_oe, 0);
        check(bus_alo == dev_la[7:0], "R2", "low address held in read phase", bus_alo, dev_la[7:0]);
        bus_ad_i = pat(dev_la);
      end else begin
        bus_ad_i = 8'hXX ^ 8'hXX;
      end
      if (bus_wr) begin
        check(bus_ad_oe, "R4", "shared port driven on write", bus_ad_oe, 1);
        if (q_wr.size() == 0)
          check(0, "R4", "unexpected write phase", {dev_la, bus_ad_o}, 0);
        else begin
          logic [23:0] ew;
          ew = q_wr.pop_front();
          check({dev_la, bus_ad_o} == ew, "R4", "write address and byte", {dev_la, bus_ad_o}, ew);
        end
      end
      if (rsp_valid) begin
        if (q_rsp.size() == 0)
          check(0, "R7", "unexpected response", rsp_rdata, 0);
        else begin
          logic [16:0] er;
          er = q_rsp.pop_front();
          if (er[16])
            check(rsp_rdata == er[15:0], "R6", "assembled read word", rsp_rdata, er[15:0]);
        end
      end
      if (!busy)
        check(!(bus_ale || bus_rd || bus_wr || bus_ad_oe), "R9", "idle bus quiet",
              {bus_ale, bus_rd, bus_wr, bus_ad_oe}, 0);
    end
  end

  // Driver: one access, optionally presenting a second request while busy.
  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input bit poke);
    logic [15:0] a2;
    a2 = a + 16'd1;
    @(negedge clk);
    check(req_ready && !busy, "R8", "ready before request", {req_ready, busy}, 2'b10);
    q_addr.push_back(a);
    q_addr.push_back(a2);
    if (wr) begin
      q_wr.push_back({a, d[15:8]});
      q_wr.push_back({a2, d[7:0]});
      q_rsp.push_back({1'b0, 16'h0});
    end else begin
      q_rsp.push_back({1'b1, pat(a), pat(a2)});
    end
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i == 1) begin
        req_valid = poke;
        req_addr  = ~a;
        req_write = ~wr;
        req_wdata = ~d;
      end
      check(busy && !req_ready, "R8", "busy during transfer", {busy, req_ready}, 2'b10);
      check(rsp_valid == (i == 5), "R7", "response timing", rsp_valid, (i == 5));
      if (i == 1)
        check(bus_ale, "R1", "address phase one cycle after accept", bus_ale, 1);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check(!busy && req_ready, "R8", "idle after response", {busy, req_ready}, 2'b01);
    check(!rsp_valid, "R7", "response is one cycle", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready && !busy && !rsp_valid, "R8", "reset state", {req_ready, busy, rsp_valid}, 3'b100);
    check(!(bus_ale || bus_rd || bus_wr || bus_ad_oe), "R9", "reset bus idle",
          {bus_ale, bus_rd, bus_wr, bus_ad_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1", "ready after reset", req_ready, 1);
    access(1'b0, 16'h1000, 16'h0000, 1'b0);
    access(1'b1, 16'h2345, 16'hBEEF, 1'b0);
    access(1'b0, 16'hFFFF, 16'h0000, 1'b0);   // R3 wrap on read
    access(1'b1, 16'hFFFF, 16'h1357, 1'b0);   // R3 wrap on write
    access(1'b0, 16'h80FF, 16'h0000, 1'b1);   // R1 request while busy ignored
    access(1'b1, 16'h00FE, 16'hA55A, 1'b1);
    access(1'b0, 16'h0000, 16'h0000, 1'b0);
    access(1'b1, 16'h7FFF, 16'h00FF, 1'b0);
    repeat (4) @(negedge clk);
    check(q_addr.size() == 0 && q_wr.size() == 0 && q_rsp.size() == 0, "R1",
          "all expected bus cycles seen and no extra", q_addr.size() + q_wr.size() + q_rsp.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule